// File: doc/BRIEF.md
# Legacy memory attribute steering decoder

This block decides, for every memory cycle that falls in the legacy window between 768 KB and 1 MB, whether the cycle is served by main DRAM or passed down to the downstream I/O link. The window is split into thirteen segments: twelve 16 KB segments from 0C0000h to 0EFFFFh and one 64 KB segment from 0F0000h to 0FFFFFh. Each segment has its own two-bit attribute made of a read-enable bit and a write-enable bit. A read and a write to the same address can therefore go to different targets. The attributes apply in the same way to host cycles and to cycles started by a peripheral.

Seven 8-bit attribute registers hold the segment attributes. They sit on a simple configuration port that has a byte offset, a write strobe, write data and combinational read data. The request port takes an address, a read/write flag, a flag that marks a downstream-originated cycle, and a valid strobe. One cycle later the block returns a registered routing decision. It also returns a hazard flag. The flag marks a downstream-originated cycle that hits a segment that is not fully readable and writable, because such a cycle can hang the memory controller.

Top module: `legacy_route_dec`

## Requirements
- R1: After reset all seven attribute registers read 00h, and every read or write in the legacy window is routed downstream (rsp_to_dram = 0).
- R2: The attribute registers are at configuration offsets 90h to 96h. A read of any other offset returns 00h, and a write to any other offset changes no register.
- R3: Register 90h keeps only bits 5:4. Registers 91h to 96h keep only bits 5:4 and 1:0. All other bits read back as 0, and writes to them are ignored.
- R4: Register 90h bits 5:4 control 0F0000h–0FFFFFh. Register 91h+n (n = 0..5) controls two segments. Bits 1:0 control the 16 KB segment at 0C0000h + n·8000h. Bits 5:4 control the 16 KB segment directly above it.
- R5: Within a field, bit 0 is read-enable and bit 1 is write-enable. The encodings are: 00 sends reads and writes downstream; 01 sends reads to DRAM and writes downstream; 10 sends writes to DRAM and reads downstream; 11 sends both to DRAM.
- R6: An address below 0C0000h, or at 100000h or above, is always routed to DRAM and never raises the hazard flag.
- R7: rsp_hazard is 1 only for an in-window request with req_from_dn = 1 whose segment field is not 11. A host request never raises it.
- R8: rsp_valid, rsp_to_dram and rsp_hazard are registered one cycle after a request with req_valid = 1. In a cycle that follows no request, all three are 0.
- R9: A register write in the same cycle as a request does not affect that request. It takes effect from the next request onward.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_ofs | input | 8 | Configuration byte offset |
| cfg_wdata | input | 8 | Configuration write data |
| cfg_rdata | output | 8 | Read data of the register at cfg_ofs (combinational) |
| req_valid | input | 1 | Request strobe |
| req_addr | input | 32 | Request byte address |
| req_is_write | input | 1 | 1 = write cycle, 0 = read cycle |
| req_from_dn | input | 1 | 1 = cycle originated on the downstream side |
| rsp_valid | output | 1 | Routing decision valid |
| rsp_to_dram | output | 1 | 1 = DRAM, 0 = downstream |
| rsp_hazard | output | 1 | Downstream-originated hit on a segment that is not fully enabled |

## Verification
The hardest case to reach from the ports is a configuration write that lands in the same clock edge as a request to the segment it reprograms. The request must still see the old attribute (R9). The bench drives the write strobe and the request valid on the same falling edge, with a new value that reverses the routing. It checks the old routing on that request, then sends a second request to show the new value. Segment edges are the other subtle area. The table sends the first and last byte of each programmed segment with opposite read/write and origin flags, so a one-off error in the segment decode or a swap of the lower and upper halves shows up as a wrong route or a wrong hazard flag.

// File: rtl/lrd_pkg.sv
// Shared types for the legacy attribute steering decoder.
// Assumes byte-wide configuration registers and two-bit segment fields.
package lrd_pkg;
    localparam int unsigned CFG_DW = 8;

    // Segment field: bit 0 read-enable, bit 1 write-enable
    typedef logic [1:0] attr_t;

    typedef enum logic [1:0] {
        ATTR_OFF = 2'b00,
        ATTR_RD  = 2'b01,
        ATTR_WR  = 2'b10,
        ATTR_RW  = 2'b11
    } attr_e;
endpackage

// File: rtl/lrd_attr_regs.sv
// Attribute register file. Register 0 keeps one field (bits 5:4); the others
// keep two (bits 5:4 and 1:0). Unkept bits read as zero. Assumes offsets
// BASE_OFS .. BASE_OFS+NUM_REGS-1 fit inside the OFS_W range.
module lrd_attr_regs
    import lrd_pkg::*;
#(
    parameter int unsigned NUM_REGS = 7,
    parameter int unsigned OFS_W    = 8,
    parameter logic [OFS_W-1:0] BASE_OFS = 8'h90
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       cfg_we,
    input  logic [OFS_W-1:0]           cfg_ofs,
    input  logic [CFG_DW-1:0]          cfg_wdata,
    output logic [CFG_DW-1:0]          cfg_rdata,
    output logic [NUM_REGS-1:0][1:0]   fld_lo,
    output logic [NUM_REGS-1:0][1:0]   fld_hi
);
    logic [OFS_W-1:0] rel_ofs;
    logic             ofs_hit;
    logic             unused_rsvd;

    // Offset relative to the first register and range check
    assign rel_ofs = cfg_ofs - BASE_OFS;
    assign ofs_hit = (cfg_ofs >= BASE_OFS) && (rel_ofs < OFS_W'(NUM_REGS));

    // Reserved write data bits are dropped on purpose
    assign unused_rsvd = ^{cfg_wdata[7:6], cfg_wdata[3:2]};

    for (genvar i = 0; i < NUM_REGS; i++) begin : g_reg
        logic wr_sel;
        assign wr_sel = cfg_we && ofs_hit && (rel_ofs == OFS_W'(i));

        // Upper field storage, present in every register
        always_ff @(posedge clk) begin
            if (!rst_n)      fld_hi[i] <= 2'b00;
            else if (wr_sel) fld_hi[i] <= cfg_wdata[5:4];
        end

        if (i == 0) begin : g_top_only
            assign fld_lo[i] = 2'b00;
        end else begin : g_pair
            // Lower field storage, only in paired registers
            always_ff @(posedge clk) begin
                if (!rst_n)      fld_lo[i] <= 2'b00;
                else if (wr_sel) fld_lo[i] <= cfg_wdata[1:0];
            end
        end

        // R2: a register not addressed by a write keeps its value
        assert_hold_unwritten_R2: assert property (@(posedge clk) disable iff (!rst_n)
            !(cfg_we && cfg_ofs == BASE_OFS + OFS_W'(i)) |=> $stable(fld_hi[i]) && $stable(fld_lo[i]));
    end

    // Read mux over the addressed register
    always_comb begin
        cfg_rdata = '0;
        for (int i = 0; i < NUM_REGS; i++) begin
            if (ofs_hit && rel_ofs == OFS_W'(i))
                cfg_rdata = {2'b00, fld_hi[i], 2'b00, fld_lo[i]};
        end
    end

    // R3: reserved positions always read zero
    assert_rsvd_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_rdata[7:6] == 2'b00 && cfg_rdata[3:2] == 2'b00);
    // R3: top register never shows a lower field
    assert_top_lo_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_ofs == BASE_OFS) |-> cfg_rdata[1:0] == 2'b00);
endmodule

// File: rtl/lrd_seg_lookup.sv
// Address to segment lookup. The lower part of the window is cut into
// 2*(NUM_REGS-1) segments of 2**SEG_SH bytes from WIN_BASE; a single segment
// of 2**TOP_SH bytes follows. Assumes ADDR_W is wide enough for the window end.
module lrd_seg_lookup
    import lrd_pkg::*;
#(
    parameter int unsigned NUM_REGS = 7,
    parameter int unsigned ADDR_W   = 32,
    parameter int unsigned SEG_SH   = 14,
    parameter int unsigned TOP_SH   = 16,
    parameter logic [ADDR_W-1:0] WIN_BASE = 32'h000C_0000
) (
    input  logic [ADDR_W-1:0]          req_addr,
    input  logic [NUM_REGS-1:0][1:0]   fld_lo,
    input  logic [NUM_REGS-1:0][1:0]   fld_hi,
    output logic                       in_map,
    output attr_t                      attr
);
    localparam int unsigned N_SMALL = 2 * (NUM_REGS - 1);
    localparam logic [ADDR_W-1:0] TOP_BASE = WIN_BASE + (ADDR_W'(N_SMALL) << SEG_SH);
    localparam logic [ADDR_W-1:0] WIN_END  = TOP_BASE + (ADDR_W'(1) << TOP_SH);

    logic              in_small;
    logic              in_top;
    logic [ADDR_W-1:0] seg_idx;

    // Window classification
    assign in_small = (req_addr >= WIN_BASE) && (req_addr < TOP_BASE);
    assign in_top   = (req_addr >= TOP_BASE) && (req_addr < WIN_END);
    assign in_map   = in_small || in_top;
    assign seg_idx  = (req_addr - WIN_BASE) >> SEG_SH;

    // Field selection for the hit segment
    always_comb begin
        attr = ATTR_OFF;
        if (in_top) attr = fld_hi[0];
        for (int r = 1; r < NUM_REGS; r++) begin
            if (in_small && seg_idx == ADDR_W'(2 * (r - 1))) attr = fld_lo[r];
            if (in_small && seg_idx == ADDR_W'(2 * r - 1))   attr = fld_hi[r];
        end
    end
endmodule

// File: rtl/lrd_route_stage.sv
// Registered routing decision. Out-of-window cycles go to DRAM; in-window
// cycles follow the segment attribute. Assumes attribute and window flag are
// stable combinational inputs during a request cycle.
module lrd_route_stage
    import lrd_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  logic  req_valid,
    input  logic  req_is_write,
    input  logic  req_from_dn,
    input  logic  in_map,
    input  attr_t attr,
    output logic  rsp_valid,
    output logic  rsp_to_dram,
    output logic  rsp_hazard
);
    logic dram_nxt;
    logic haz_nxt;

    // Decision from direction and enable bits
    always_comb begin
        dram_nxt = 1'b1;
        haz_nxt  = 1'b0;
        if (in_map) begin
            dram_nxt = req_is_write ? attr[1] : attr[0];
            haz_nxt  = req_from_dn && (attr != ATTR_RW);
        end
    end

    // Response register, cleared when no request was presented
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_valid   <= 1'b0;
            rsp_to_dram <= 1'b0;
            rsp_hazard  <= 1'b0;
        end else begin
            rsp_valid   <= req_valid;
            rsp_to_dram <= req_valid && dram_nxt;
            rsp_hazard  <= req_valid && haz_nxt;
        end
    end

    // R8: a response follows exactly the cycles that carried a request
    assert_rsp_follows_req_R8: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> rsp_valid);
    assert_idle_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !rsp_valid |-> !rsp_to_dram && !rsp_hazard);
    // R7: a hazard always traces back to a downstream-originated request
    assert_hazard_from_dn_R7: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && !req_from_dn |=> !rsp_hazard);
endmodule

// File: rtl/legacy_route_dec.sv
// Legacy memory attribute steering decoder, top level. Holds the attribute
// registers, looks up the segment of each request and registers the routing
// decision plus the downstream hazard flag. Assumes one request per cycle.
module legacy_route_dec
    import lrd_pkg::*;
#(
    parameter int unsigned NUM_REGS = 7,
    parameter int unsigned ADDR_W   = 32,
    parameter int unsigned OFS_W    = 8,
    parameter logic [OFS_W-1:0]  BASE_OFS = 8'h90,
    parameter logic [ADDR_W-1:0] WIN_BASE = 32'h000C_0000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [OFS_W-1:0]  cfg_ofs,
    input  logic [7:0]        cfg_wdata,
    output logic [7:0]        cfg_rdata,
    input  logic              req_valid,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic              req_is_write,
    input  logic              req_from_dn,
    output logic              rsp_valid,
    output logic              rsp_to_dram,
    output logic              rsp_hazard
);
    localparam int unsigned SEG_SH = 14;
    localparam int unsigned TOP_SH = 16;
    localparam logic [ADDR_W-1:0] WIN_END = WIN_BASE
        + (ADDR_W'(2 * (NUM_REGS - 1)) << SEG_SH) + (ADDR_W'(1) << TOP_SH);

    logic [NUM_REGS-1:0][1:0] fld_lo;
    logic [NUM_REGS-1:0][1:0] fld_hi;
    logic                     in_map;
    attr_t                    attr;

    lrd_attr_regs #(
        .NUM_REGS (NUM_REGS),
        .OFS_W    (OFS_W),
        .BASE_OFS (BASE_OFS)
    ) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg_we    (cfg_we),
        .cfg_ofs   (cfg_ofs),
        .cfg_wdata (cfg_wdata),
        .cfg_rdata (cfg_rdata),
        .fld_lo    (fld_lo),
        .fld_hi    (fld_hi)
    );

    lrd_seg_lookup #(
        .NUM_REGS (NUM_REGS),
        .ADDR_W   (ADDR_W),
        .SEG_SH   (SEG_SH),
        .TOP_SH   (TOP_SH),
        .WIN_BASE (WIN_BASE)
    ) u_lookup (
        .req_addr (req_addr),
        .fld_lo   (fld_lo),
        .fld_hi   (fld_hi),
        .in_map   (in_map),
        .attr     (attr)
    );

    lrd_route_stage u_route (
        .clk          (clk),
        .rst_n        (rst_n),
        .req_valid    (req_valid),
        .req_is_write (req_is_write),
        .req_from_dn  (req_from_dn),
        .in_map       (in_map),
        .attr         (attr),
        .rsp_valid    (rsp_valid),
        .rsp_to_dram  (rsp_to_dram),
        .rsp_hazard   (rsp_hazard)
    );

    // R6: addresses outside the window go to DRAM with no hazard
    assert_outside_dram_R6: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && (req_addr < WIN_BASE || req_addr >= WIN_END)
        |=> rsp_to_dram && !rsp_hazard);
endmodule

// File: tb/legacy_route_dec_test.sv
module legacy_route_dec_test;
    localparam int CLK_PERIOD = 10;
    localparam int N_VEC = 21;

    // {addr[35:4], is_write[3], from_dn[2], exp_dram[1], exp_hazard[0]}
    localparam logic [35:0] VEC [N_VEC] = '{
        {32'h000C_0000, 1'b0, 1'b0, 1'b1, 1'b0},
        {32'h000C_3FFF, 1'b1, 1'b0, 1'b0, 1'b0},
        {32'h000C_3FFF, 1'b0, 1'b1, 1'b1, 1'b1},
        {32'h000C_4000, 1'b0, 1'b0, 1'b0, 1'b0},
        {32'h000C_7FFF, 1'b1, 1'b0, 1'b1, 1'b0},
        {32'h000C_4000, 1'b1, 1'b1, 1'b1, 1'b1},
        {32'h000C_8000, 1'b0, 1'b1, 1'b1, 1'b0},
        {32'h000C_BFFF, 1'b1, 1'b1, 1'b1, 1'b0},
        {32'h000C_C000, 1'b0, 1'b0, 1'b0, 1'b0},
        {32'h000C_FFFF, 1'b1, 1'b1, 1'b0, 1'b1},
        {32'h000D_0000, 1'b1, 1'b0, 1'b1, 1'b0},
        {32'h000D_3FFF, 1'b0, 1'b0, 1'b0, 1'b0},
        {32'h000D_4000, 1'b0, 1'b0, 1'b1, 1'b0},
        {32'h000D_7FFF, 1'b1, 1'b0, 1'b0, 1'b0},
        {32'h000D_8000, 1'b0, 1'b0, 1'b0, 1'b0},
        {32'h000E_FFFF, 1'b1, 1'b1, 1'b0, 1'b1},
        {32'h000F_0000, 1'b0, 1'b1, 1'b1, 1'b0},
        {32'h000F_FFFF, 1'b1, 1'b0, 1'b1, 1'b0},
        {32'h000B_FFFF, 1'b0, 1'b1, 1'b1, 1'b0},
        {32'h0010_0000, 1'b1, 1'b1, 1'b1, 1'b0},
        {32'h0000_0000, 1'b1, 1'b0, 1'b1, 1'b0}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [7:0]  cfg_ofs = 8'h00;
    logic [7:0]  cfg_wdata = 8'h00;
    logic [7:0]  cfg_rdata;
    logic        req_valid = 1'b0;
    logic [31:0] req_addr = 32'h0;
    logic        req_is_write = 1'b0;
    logic        req_from_dn = 1'b0;
    logic        rsp_valid;
    logic        rsp_to_dram;
    logic        rsp_hazard;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    legacy_route_dec uut (
        .clk          (clk),
        .rst_n        (rst_n),
        .cfg_we       (cfg_we),
        .cfg_ofs      (cfg_ofs),
        .cfg_wdata    (cfg_wdata),
        .cfg_rdata    (cfg_rdata),
        .req_valid    (req_valid),
        .req_addr     (req_addr),
        .req_is_write (req_is_write),
        .req_from_dn  (req_from_dn),
        .rsp_valid    (rsp_valid),
        .rsp_to_dram  (rsp_to_dram),
        .rsp_hazard   (rsp_hazard)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic cfg_write(input logic [7:0] ofs, input logic [7:0] data);
        @(negedge clk);
        cfg_we = 1'b1; cfg_ofs = ofs; cfg_wdata = data;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic cfg_check(input string tag, input logic [7:0] ofs, input logic [7:0] exp);
        @(negedge clk);
        cfg_ofs = ofs;
        #1;
        chk(tag, {24'h0, cfg_rdata}, {24'h0, exp});
    endtask

    // Presents one request and checks the registered response
    task automatic send_req(input string tag, input logic [31:0] addr, input logic wr,
                            input logic dn, input logic exp_dram, input logic exp_haz);
        @(negedge clk);
        req_valid = 1'b1; req_addr = addr; req_is_write = wr; req_from_dn = dn;
        @(negedge clk);
        req_valid = 1'b0;
        chk({tag, " valid"}, {31'h0, rsp_valid}, 32'h1);
        chk({tag, " route"}, {31'h0, rsp_to_dram}, {31'h0, exp_dram});
        chk({tag, " hazard"}, {31'h0, rsp_hazard}, {31'h0, exp_haz});
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1: reset values and downstream routing
        @(negedge clk);
        chk("R1 rsp_valid idle", {31'h0, rsp_valid}, 32'h0);
        for (int i = 0; i < 7; i++) cfg_check("R1 reset readback", 8'h90 + 8'(i), 8'h00);
        send_req("R1 read C0000", 32'h000C_0000, 1'b0, 1'b0, 1'b0, 1'b0);
        send_req("R1 write FFFFF", 32'h000F_FFFF, 1'b1, 1'b0, 1'b0, 1'b0);

        // R2/R3: programming, reserved bits and unmapped offsets
        cfg_write(8'h90, 8'hFF);
        cfg_check("R3 top reg readback", 8'h90, 8'h30);
        cfg_write(8'h91, 8'h21);
        cfg_write(8'h92, 8'hCF);
        cfg_check("R3 pair reg readback", 8'h92, 8'h03);
        cfg_write(8'h93, 8'h12);
        cfg_check("R2 reg 93 readback", 8'h93, 8'h12);
        cfg_write(8'h97, 8'hFF);
        cfg_write(8'h8F, 8'hFF);
        cfg_check("R2 unmapped 97", 8'h97, 8'h00);
        cfg_check("R2 unmapped 8F", 8'h8F, 8'h00);
        cfg_check("R2 reg 94 untouched", 8'h94, 8'h00);
        cfg_check("R2 reg 96 untouched", 8'h96, 8'h00);

        // R4/R5/R6/R7: table of boundary requests
        for (int v = 0; v < N_VEC; v++) begin
            send_req($sformatf("R4 R5 R6 R7 vec%0d", v), VEC[v][35:4], VEC[v][3],
                     VEC[v][2], VEC[v][1], VEC[v][0]);
        end

        // R8: idle cycle after a request carries nothing
        @(negedge clk);
        chk("R8 idle valid", {31'h0, rsp_valid}, 32'h0);
        chk("R8 idle route", {31'h0, rsp_to_dram}, 32'h0);
        chk("R8 idle hazard", {31'h0, rsp_hazard}, 32'h0);

        // R9: write in the same cycle as a request uses the old attribute
        @(negedge clk);
        cfg_we = 1'b1; cfg_ofs = 8'h90; cfg_wdata = 8'h00;
        req_valid = 1'b1; req_addr = 32'h000F_8000; req_is_write = 1'b0; req_from_dn = 1'b1;
        @(negedge clk);
        cfg_we = 1'b0; req_valid = 1'b0;
        chk("R9 same-cycle route", {31'h0, rsp_to_dram}, 32'h1);
        chk("R9 same-cycle hazard", {31'h0, rsp_hazard}, 32'h0);
        send_req("R9 next request", 32'h000F_8000, 1'b0, 1'b1, 1'b0, 1'b1);

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule